// File: doc/BRIEF.md
# MSI and Core Event Interrupt Aggregator

This block gathers message-signalled interrupts and legacy core events for a PCIe root complex and reduces them to a single level-sensitive interrupt line toward the processor. Each inbound MSI arrives as a 16-bit interrupt number with a one-cycle valid strobe. Only the five least significant bits of that number are used. They select one of 32 pending classes, so every number that shares those bits lands in the same class and is gated by the same mask bit.

Six core event inputs cover power management, error and the four legacy INTx wires. They latch into their own pending register. Two group summaries, one for MSI and one for core events, each pass through a summary mask. They are then ORed and gated by a final top mask to form the output line. Software uses a simple register port for all control: a write strobe with address and data, and a combinational read. Pending bits are acknowledged by writing ones. A debug register keeps the last full MSI number, and a sticky flag records an MSI that arrived for a class that was already pending.

Top module: `irq_agg_top`

## Requirements
- R1: After reset, all pending registers, the last-number register and the repeat flag read 0. MSI control reads 0. The class mask reads 0xFFFFFFFF, the core mask reads 0x3F, the top mask reads 0x7, and irq_o is 0.
- R2: When MSI control bit 0 is set, an accepted MSI sets pending bit num[4:0] of the class status register (0x04) whatever its upper 11 bits are. The full number is then readable at 0x18.
- R3: When MSI control bit 0 is clear, an arriving MSI changes no pending bit, does not update the last-number register and does not set the repeat flag.
- R4: A class pending bit is set even when its class mask bit (0x08, 1 = masked) is set. Clearing that mask bit while the class is still pending raises the MSI summary, and with it irq_o, at once.
- R5: Top mask bit 1 blocks the MSI summary from irq_o while the class pending bits stay readable.
- R6: A high core event input sets its bit in the core status register (0x0C). The bit order is pme 0, err 1, inta 2, intb 3, intc 4, intd 5. Core mask bits at 0x10 (1 = masked) gate each source into the core summary, and top mask bit 0 blocks the core summary.
- R7: Top mask bit 2 forces irq_o low. With it clear, irq_o is the OR of the two unblocked summaries, as a level.
- R8: The class status, core status and repeat flag registers are write-one-to-clear. A set that arrives in the same cycle as a clear of the same bit leaves the bit set.
- R9: The last-number register at 0x18 is read-only, and writes to it have no effect.
- R10: An accepted MSI whose class is already pending sets the sticky repeat flag at 0x1C bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| msi_valid_i | input | 1 | One-cycle strobe for an inbound MSI |
| msi_num_i | input | 16 | MSI interrupt number |
| core_ev_i | input | 6 | Core event inputs: pme, err, inta..intd |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| irq_o | output | 1 | Aggregated interrupt level |

## Verification
The bench sends MSI numbers that differ only in their upper bits. A design that decoded more than five bits would set the wrong pending bit or none at all. It collides an MSI or a core event with a write-one-to-clear of the same bit, where a design that gave the clear priority would lose an interrupt. It leaves a class pending while masked and then unmasks it, checking that irq_o rises with no new MSI. It also sends MSIs with the global enable off and writes to the read-only last-number register, where a leaky design would change the status, the repeat flag or the captured number.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned ADDR_W   = 8;
  localparam int unsigned NUM_W    = 16;
  localparam int unsigned CLASS_W  = 5;
  localparam int unsigned N_CLASS  = 1 << CLASS_W;
  localparam int unsigned N_CORE   = 6;

  localparam logic [ADDR_W-1:0] OFF_MSI_CTRL = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_MSI_STAT = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_MSI_MASK = 8'h08;
  localparam logic [ADDR_W-1:0] OFF_CORE_ST  = 8'h0C;
  localparam logic [ADDR_W-1:0] OFF_CORE_MSK = 8'h10;
  localparam logic [ADDR_W-1:0] OFF_TOP_MSK  = 8'h14;
  localparam logic [ADDR_W-1:0] OFF_LAST_NUM = 8'h18;
  localparam logic [ADDR_W-1:0] OFF_REPEAT   = 8'h1C;

  typedef struct packed {
    logic out_blk;   // bit 2
    logic msi_blk;   // bit 1
    logic core_blk;  // bit 0
  } top_mask_t;
endpackage

// File: rtl/irq_msi_bank.sv
module irq_msi_bank #(
  parameter int unsigned NUM_W   = 16,
  parameter int unsigned CLASS_W = 5,
  localparam int unsigned N_CLASS = 1 << CLASS_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               valid_i,
  input  logic [NUM_W-1:0]   num_i,
  input  logic [N_CLASS-1:0] clr_i,
  input  logic               mask_we_i,
  input  logic [N_CLASS-1:0] mask_wdata_i,
  input  logic               rep_clr_i,
  output logic [N_CLASS-1:0] status_o,
  output logic [N_CLASS-1:0] mask_o,
  output logic [NUM_W-1:0]   last_o,
  output logic               rep_o,
  output logic               pend_o
);
  logic [N_CLASS-1:0] status_q, mask_q, set_vec;
  logic [NUM_W-1:0]   last_q;
  logic               rep_q, accept;
  logic [CLASS_W-1:0] cls;

  assign accept = valid_i & en_i;
  assign cls    = num_i[CLASS_W-1:0];

  for (genvar i = 0; i < N_CLASS; i++) begin : g_class
    assign set_vec[i] = accept && (cls == CLASS_W'(i));
    // set has priority over a same-cycle W1C
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         status_q[i] <= 1'b0;
      else if (set_vec[i]) status_q[i] <= 1'b1;
      else if (clr_i[i])   status_q[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '1;
      last_q <= '0;
      rep_q  <= 1'b0;
    end else begin
      if (mask_we_i) mask_q <= mask_wdata_i;
      if (accept)    last_q <= num_i;
      if (accept && status_q[cls]) rep_q <= 1'b1;
      else if (rep_clr_i)          rep_q <= 1'b0;
    end
  end

  assign status_o = status_q;
  assign mask_o   = mask_q;
  assign last_o   = last_q;
  assign rep_o    = rep_q;
  assign pend_o   = |(status_q & ~mask_q);

  p_class_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && en_i |=> status_q[$past(num_i[CLASS_W-1:0])]);
  p_disabled_ignored_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !en_i && clr_i == '0 |=> status_q == $past(status_q) && $stable(last_q));
  p_last_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_i && en_i) |=> $stable(last_q));
  p_repeat_flag_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && en_i && status_q[num_i[CLASS_W-1:0]] |=> rep_q);
endmodule

// File: rtl/irq_core_bank.sv
module irq_core_bank #(
  parameter int unsigned N_SRC = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] ev_i,
  input  logic [N_SRC-1:0] clr_i,
  input  logic             mask_we_i,
  input  logic [N_SRC-1:0] mask_wdata_i,
  output logic [N_SRC-1:0] status_o,
  output logic [N_SRC-1:0] mask_o,
  output logic             pend_o
);
  logic [N_SRC-1:0] status_q, mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      mask_q   <= '1;
    end else begin
      status_q <= ev_i | (status_q & ~clr_i);
      if (mask_we_i) mask_q <= mask_wdata_i;
    end
  end

  assign status_o = status_q;
  assign mask_o   = mask_q;
  assign pend_o   = |(status_q & ~mask_q);

  p_core_capture_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_i != '0 |=> (status_q & $past(ev_i)) == $past(ev_i));
  p_set_beats_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_i & clr_i) != '0 |=> (status_q & $past(ev_i & clr_i)) == $past(ev_i & clr_i));
endmodule

// File: rtl/irq_agg_top.sv
module irq_agg_top
  import irq_agg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              msi_valid_i,
  input  logic [NUM_W-1:0]  msi_num_i,
  input  logic [N_CORE-1:0] core_ev_i,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o
);
  logic              msi_en_q;
  top_mask_t         top_mask_q;
  logic [N_CLASS-1:0] msi_status, msi_mask;
  logic [N_CORE-1:0]  core_status, core_mask;
  logic [NUM_W-1:0]   last_num;
  logic               repeat_flag, msi_pend, core_pend;
  logic wr_ctrl, wr_stat, wr_mask, wr_cst, wr_cmsk, wr_top, wr_rep;

  assign wr_ctrl = reg_wr_i && reg_addr_i == OFF_MSI_CTRL;
  assign wr_stat = reg_wr_i && reg_addr_i == OFF_MSI_STAT;
  assign wr_mask = reg_wr_i && reg_addr_i == OFF_MSI_MASK;
  assign wr_cst  = reg_wr_i && reg_addr_i == OFF_CORE_ST;
  assign wr_cmsk = reg_wr_i && reg_addr_i == OFF_CORE_MSK;
  assign wr_top  = reg_wr_i && reg_addr_i == OFF_TOP_MSK;
  assign wr_rep  = reg_wr_i && reg_addr_i == OFF_REPEAT;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      msi_en_q   <= 1'b0;
      top_mask_q <= '1;
    end else begin
      if (wr_ctrl) msi_en_q   <= reg_wdata_i[0];
      if (wr_top)  top_mask_q <= top_mask_t'(reg_wdata_i[2:0]);
    end
  end

  irq_msi_bank #(.NUM_W(NUM_W), .CLASS_W(CLASS_W)) u_msi (
    .clk_i, .rst_ni,
    .en_i        (msi_en_q),
    .valid_i     (msi_valid_i),
    .num_i       (msi_num_i),
    .clr_i       (wr_stat ? reg_wdata_i[N_CLASS-1:0] : '0),
    .mask_we_i   (wr_mask),
    .mask_wdata_i(reg_wdata_i[N_CLASS-1:0]),
    .rep_clr_i   (wr_rep && reg_wdata_i[0]),
    .status_o    (msi_status),
    .mask_o      (msi_mask),
    .last_o      (last_num),
    .rep_o       (repeat_flag),
    .pend_o      (msi_pend)
  );

  irq_core_bank #(.N_SRC(N_CORE)) u_core (
    .clk_i, .rst_ni,
    .ev_i        (core_ev_i),
    .clr_i       (wr_cst ? reg_wdata_i[N_CORE-1:0] : '0),
    .mask_we_i   (wr_cmsk),
    .mask_wdata_i(reg_wdata_i[N_CORE-1:0]),
    .status_o    (core_status),
    .mask_o      (core_mask),
    .pend_o      (core_pend)
  );

  assign irq_o = !top_mask_q.out_blk &&
                 ((msi_pend && !top_mask_q.msi_blk) || (core_pend && !top_mask_q.core_blk));

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      OFF_MSI_CTRL: reg_rdata_o[0]           = msi_en_q;
      OFF_MSI_STAT: reg_rdata_o[N_CLASS-1:0] = msi_status;
      OFF_MSI_MASK: reg_rdata_o[N_CLASS-1:0] = msi_mask;
      OFF_CORE_ST:  reg_rdata_o[N_CORE-1:0]  = core_status;
      OFF_CORE_MSK: reg_rdata_o[N_CORE-1:0]  = core_mask;
      OFF_TOP_MSK:  reg_rdata_o[2:0]         = top_mask_q;
      OFF_LAST_NUM: reg_rdata_o[NUM_W-1:0]   = last_num;
      OFF_REPEAT:   reg_rdata_o[0]           = repeat_flag;
      default:      reg_rdata_o              = '0;
    endcase
  end

  p_quiet_when_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msi_status == '0 && core_status == '0 |-> !irq_o);
  p_unmasked_pending_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    top_mask_q == '0 && (msi_status & ~msi_mask) != '0 |-> irq_o);
endmodule

// File: tb/irq_agg_top_tb.sv
module irq_agg_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        msi_valid = 1'b0;
  logic [15:0] msi_num = '0;
  logic [5:0]  core_ev = '0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_agg_top u_dut (
    .clk_i(clk), .rst_ni(rst_n), .msi_valid_i(msi_valid), .msi_num_i(msi_num),
    .core_ev_i(core_ev), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .irq_o(irq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd_chk(string req, logic [7:0] a, logic [31:0] exp);
    @(negedge clk); reg_addr = a; #1;
    check(req, reg_rdata, exp);
  endtask

  task automatic send(logic [15:0] n);
    @(negedge clk); msi_valid = 1'b1; msi_num = n;
    @(negedge clk); msi_valid = 1'b0;
  endtask

  task automatic t_reset;
    rd_chk("R1 ctrl", 8'h00, 32'h0);
    rd_chk("R1 msi stat", 8'h04, 32'h0);
    rd_chk("R1 msi mask", 8'h08, 32'hFFFF_FFFF);
    rd_chk("R1 core stat", 8'h0C, 32'h0);
    rd_chk("R1 core mask", 8'h10, 32'h3F);
    rd_chk("R1 top mask", 8'h14, 32'h7);
    rd_chk("R1 last", 8'h18, 32'h0);
    rd_chk("R1 repeat", 8'h1C, 32'h0);
    check("R1 irq", irq, 0);
  endtask

  task automatic t_classify;
    wr(8'h00, 32'h1);
    send(16'h0025);
    rd_chk("R2 class 5", 8'h04, 32'h0000_0020);
    rd_chk("R2 last", 8'h18, 32'h0025);
    send(16'hFFE3);
    rd_chk("R2 class 3 from high num", 8'h04, 32'h0000_0028);
    rd_chk("R2 last high", 8'h18, 32'hFFE3);
    check("R4 masked class no irq", irq, 0);
  endtask

  task automatic t_unmask;
    wr(8'h14, 32'h0);
    check("R4 still masked", irq, 0);
    wr(8'h08, ~32'h20);
    check("R4 unmask pending raises irq", irq, 1);
    wr(8'h14, 32'h2);
    check("R5 msi summary blocked", irq, 0);
    rd_chk("R5 status readable", 8'h04, 32'h0000_0028);
    wr(8'h14, 32'h4);
    check("R7 top mask blocks", irq, 0);
    wr(8'h14, 32'h0);
    check("R7 top mask released", irq, 1);
  endtask

  task automatic t_w1c;
    wr(8'h04, 32'h20);
    rd_chk("R8 w1c clears bit 5", 8'h04, 32'h0000_0008);
    check("R8 irq drops after ack", irq, 0);
    @(negedge clk);
    msi_valid = 1'b1; msi_num = 16'h0005;
    reg_wr = 1'b1; reg_addr = 8'h04; reg_wdata = 32'h20;
    @(negedge clk);
    msi_valid = 1'b0; reg_wr = 1'b0;
    rd_chk("R8 set beats clear", 8'h04, 32'h0000_0028);
    rd_chk("R10 no repeat yet", 8'h1C, 32'h0);
  endtask

  task automatic t_repeat;
    send(16'h0045);
    rd_chk("R10 repeat flag set", 8'h1C, 32'h1);
    wr(8'h1C, 32'h1);
    rd_chk("R8 repeat flag w1c", 8'h1C, 32'h0);
    wr(8'h18, 32'h0000_1234);
    rd_chk("R9 last read-only", 8'h18, 32'h0045);
  endtask

  task automatic t_disabled;
    wr(8'h00, 32'h0);
    wr(8'h04, 32'hFFFF_FFFF);
    send(16'h0007);
    send(16'h0007);
    rd_chk("R3 no status when disabled", 8'h04, 32'h0);
    rd_chk("R3 last unchanged", 8'h18, 32'h0045);
    rd_chk("R3 no repeat flag", 8'h1C, 32'h0);
    check("R3 irq low", irq, 0);
  endtask

  task automatic t_core;
    @(negedge clk); core_ev = 6'b000100;
    @(negedge clk); core_ev = '0;
    rd_chk("R6 inta latched", 8'h0C, 32'h04);
    check("R6 masked source no irq", irq, 0);
    wr(8'h10, 32'h3B);
    check("R6 unmasked inta irq", irq, 1);
    wr(8'h14, 32'h1);
    check("R6 core summary mask", irq, 0);
    wr(8'h14, 32'h0);
    wr(8'h0C, 32'h04);
    check("R8 core ack drops irq", irq, 0);
    @(negedge clk);
    core_ev = 6'b000001;
    reg_wr = 1'b1; reg_addr = 8'h0C; reg_wdata = 32'h01;
    @(negedge clk);
    core_ev = '0; reg_wr = 1'b0;
    rd_chk("R8 core set beats clear (pme)", 8'h0C, 32'h01);
    @(negedge clk); core_ev = 6'b100000;
    @(negedge clk); core_ev = '0;
    rd_chk("R6 intd bit 5", 8'h0C, 32'h21);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_classify();
    t_unmask();
    t_w1c();
    t_repeat();
    t_disabled();
    t_core();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule